// File: doc/BRIEF.md
# Load Data Alignment and Extension Unit

This block sits between the memory read port and the register-file write port of a processor core. It takes the raw aligned word returned by memory and the two least significant bits of the access address, then produces the value that the core writes to the destination register. Word accesses return the aligned word rotated right by eight bits for each byte of misalignment. The block does not fault on a misaligned word and does not reassemble bytes from neighbouring words. Byte and halfword accesses pick one lane of the little-endian word and widen it to the full register width, filling with zeros or with copies of the lane's top bit.

When a word-sized load targets the program counter, the result is marked as a jump target with a branch request instead of a plain register write. A core-variant input clears bit 0 of that jump address. The same word rotation also serves the read half of an atomic swap, which returns the old memory word through the word path.

The result, the branch request and an output strobe are all registered. They appear one clock after the input strobe.

Top module: `load_formatter`

## Requirements
- R1: A word access (acc_size = 2) returns rd_word rotated right by 8 × addr_lo bits.
- R2: An unsigned byte access (acc_size = 0, sign_ext = 0) returns byte lane addr_lo, with lane n at bits 8n+7..8n, zero-extended to 32 bits.
- R3: A signed byte access (acc_size = 0, sign_ext = 1) fills bits 31..8 with bit 7 of the selected lane.
- R4: A halfword access (acc_size = 1) selects bits 15..0 when addr_lo[1] = 0 and bits 31..16 when addr_lo[1] = 1. addr_lo[0] has no effect, and with sign_ext = 0 the upper 16 bits are zero.
- R5: A signed halfword access (acc_size = 1, sign_ext = 1) fills bits 31..16 with bit 15 of the selected halfword.
- R6: sign_ext has no effect on word accesses.
- R7: branch_req is 1 only for a word access with dest_pc = 1. A byte or halfword access with dest_pc = 1 is an ordinary result with branch_req = 0.
- R8: With pc_bit0_clear = 1, bit 0 of the result is forced to 0 on a branch result only. Word results that are not branches keep bit 0.
- R9: out_valid equals in_valid of the previous cycle. branch_req is never 1 without out_valid. out_data holds its value in cycles with in_valid = 0.
- R10: While rst_n is low, out_valid, branch_req and out_data are all 0.
- R11: The reserved size code acc_size = 3 behaves exactly like a word access, including branch handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Read data and controls are valid this cycle |
| rd_word | input | 32 | Aligned word returned by memory |
| addr_lo | input | 2 | Low address bits of the access |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 treated as word |
| sign_ext | input | 1 | Sign-extend narrow accesses |
| dest_pc | input | 1 | Destination register is the program counter |
| pc_bit0_clear | input | 1 | Core variant that clears bit 0 of a loaded jump address |
| out_valid | output | 1 | Registered result strobe |
| out_data | output | 32 | Formatted register value |
| branch_req | output | 1 | Result is a jump target |

## Verification
Every output of this block is due exactly one rising edge after the input that produced it, because the formatting logic feeds a single register stage. The bench applies each input on a falling edge and reads the outputs on the next falling edge, half a cycle after the capturing edge. Hold behaviour is checked two falling edges after the strobe drops, once the inputs have changed. Reset values are read while reset is held, and again after a reset applied in the middle of a run.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    function automatic logic is_word_access(input acc_size_e sz);
        return (sz == SZ_WORD) || (sz == SZ_WIDE);
    endfunction

endpackage

// File: rtl/ldfmt_rotator.sv
module ldfmt_rotator #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    parameter int LANES  = DATA_W / LANE_W,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] raw,
    input  logic [OFF_W-1:0]  off,
    output logic [DATA_W-1:0] rotated
);

    logic [DATA_W-1:0] cand [LANES];

    // one candidate per lane offset: rotate right by k lanes
    for (genvar k = 0; k < LANES; k++) begin : g_rot
        if (k == 0) begin : g_zero
            assign cand[k] = raw;
        end else begin : g_shift
            assign cand[k] = {raw[k*LANE_W-1:0], raw[DATA_W-1:k*LANE_W]};
        end
    end

    assign rotated = cand[off];

endmodule

// File: rtl/ldfmt_narrow.sv
module ldfmt_narrow #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    parameter int LANES  = DATA_W / LANE_W,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] raw,
    input  logic [OFF_W-1:0]  off,
    input  logic              is_half,
    input  logic              signed_ext,
    output logic [DATA_W-1:0] widened
);

    localparam int HALF_W = 2 * LANE_W;
    localparam int HALVES = LANES / 2;

    logic [LANE_W-1:0] blane [LANES];
    logic [HALF_W-1:0] hlane [HALVES];

    for (genvar k = 0; k < LANES; k++) begin : g_byte
        assign blane[k] = raw[k*LANE_W +: LANE_W];
    end

    for (genvar j = 0; j < HALVES; j++) begin : g_half
        assign hlane[j] = raw[j*HALF_W +: HALF_W];
    end

    logic [LANE_W-1:0] bsel;
    logic [HALF_W-1:0] hsel;
    logic              fill;

    always_comb begin
        bsel = blane[off];
        hsel = hlane[off[OFF_W-1:1]];
        if (is_half) begin
            fill    = signed_ext & hsel[HALF_W-1];
            widened = {{(DATA_W-HALF_W){fill}}, hsel};
        end else begin
            fill    = signed_ext & bsel[LANE_W-1];
            widened = {{(DATA_W-LANE_W){fill}}, bsel};
        end
    end

endmodule

// File: rtl/load_formatter.sv
module load_formatter
    import ldfmt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    parameter int LANES  = DATA_W / LANE_W,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] rd_word,
    input  logic [OFF_W-1:0]  addr_lo,
    input  logic [1:0]        acc_size,
    input  logic              sign_ext,
    input  logic              dest_pc,
    input  logic              pc_bit0_clear,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              branch_req
);

    typedef struct packed {
        logic              vld;
        logic              br;
        logic [DATA_W-1:0] data;
    } fmt_state_t;

    fmt_state_t st_d, st_q;

    acc_size_e         size_e;
    logic              word_acc;
    logic [DATA_W-1:0] rot_val;
    logic [DATA_W-1:0] nar_val;

    assign size_e   = acc_size_e'(acc_size);
    assign word_acc = is_word_access(size_e);

    ldfmt_rotator #(
        .DATA_W(DATA_W), .LANE_W(LANE_W), .LANES(LANES), .OFF_W(OFF_W)
    ) i_rot (
        .raw     (rd_word),
        .off     (addr_lo),
        .rotated (rot_val)
    );

    ldfmt_narrow #(
        .DATA_W(DATA_W), .LANE_W(LANE_W), .LANES(LANES), .OFF_W(OFF_W)
    ) i_nar (
        .raw        (rd_word),
        .off        (addr_lo),
        .is_half    (size_e == SZ_HALF),
        .signed_ext (sign_ext),
        .widened    (nar_val)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.br  = in_valid && dest_pc && word_acc;
        if (in_valid) begin
            st_d.data = word_acc ? rot_val : nar_val;
            if (word_acc && dest_pc && pc_bit0_clear) begin
                st_d.data[0] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign out_data   = st_q.data;
    assign branch_req = st_q.br;

    // strobe follows input strobe by one cycle
    assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_branch_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        branch_req |-> out_valid);
    assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
    assert_byte_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_e == SZ_BYTE && !sign_ext) |=> (out_data[DATA_W-1:LANE_W] == '0));
    assert_half_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_e == SZ_HALF && sign_ext)
        |=> (out_data[DATA_W-1:2*LANE_W] == {(DATA_W-2*LANE_W){out_data[2*LANE_W-1]}}));
    assert_pc_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dest_pc && word_acc && pc_bit0_clear) |=> (branch_req && !out_data[0]));
    assert_narrow_no_branch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !word_acc) |=> !branch_req);

endmodule

// File: tb/test_load_formatter.sv
module test_load_formatter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] rd_word = '0;
    logic [1:0]  addr_lo = '0;
    logic [1:0]  acc_size = '0;
    logic        sign_ext = 1'b0;
    logic        dest_pc = 1'b0;
    logic        pc_bit0_clear = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        branch_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    load_formatter i_load_formatter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rd_word(rd_word),
        .addr_lo(addr_lo), .acc_size(acc_size), .sign_ext(sign_ext),
        .dest_pc(dest_pc), .pc_bit0_clear(pc_bit0_clear),
        .out_valid(out_valid), .out_data(out_data), .branch_req(branch_req)
    );

    typedef struct packed {
        logic [31:0] word;
        logic [1:0]  off;
        logic [1:0]  sz;
        logic        sgn;
        logic        pc;
        logic        clr;
        logic [31:0] exp_data;
        logic        exp_br;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{32'h11223344, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 32'h11223344, 1'b0, 8'd1}, // R1
        '{32'h11223344, 2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 32'h44112233, 1'b0, 8'd1}, // R1
        '{32'h11223344, 2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 32'h33441122, 1'b0, 8'd1}, // R1
        '{32'h11223344, 2'd3, 2'd2, 1'b0, 1'b0, 1'b0, 32'h22334411, 1'b0, 8'd1}, // R1
        '{32'hA1B2C3F4, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h000000F4, 1'b0, 8'd2}, // R2
        '{32'hA1B2C3F4, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 32'h000000A1, 1'b0, 8'd2}, // R2
        '{32'hA1B2C3F4, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 32'hFFFFFFC3, 1'b0, 8'd3}, // R3
        '{32'h00007F00, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0000007F, 1'b0, 8'd3}, // R3
        '{32'hA1B2C3F4, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0000C3F4, 1'b0, 8'd4}, // R4
        '{32'hA1B2C3F4, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0000C3F4, 1'b0, 8'd4}, // R4
        '{32'hA1B2C3F4, 2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0000A1B2, 1'b0, 8'd4}, // R4
        '{32'hA1B2C3F4, 2'd3, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0000A1B2, 1'b0, 8'd4}, // R4
        '{32'hA1B2C3F4, 2'd2, 2'd1, 1'b1, 1'b0, 1'b0, 32'hFFFFA1B2, 1'b0, 8'd5}, // R5
        '{32'h7FFF8000, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 32'hFFFF8000, 1'b0, 8'd5}, // R5
        '{32'h7FFF8000, 2'd2, 2'd1, 1'b1, 1'b0, 1'b0, 32'h00007FFF, 1'b0, 8'd5}, // R5
        '{32'h80000001, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 32'h80000001, 1'b0, 8'd6}, // R6
        '{32'h11223344, 2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 32'h44112233, 1'b0, 8'd6}, // R6
        '{32'h02000005, 2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 32'h02000005, 1'b1, 8'd7}, // R7
        '{32'hA1B2C3F4, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 32'h000000F4, 1'b0, 8'd7}, // R7
        '{32'h02000005, 2'd0, 2'd2, 1'b0, 1'b1, 1'b1, 32'h02000004, 1'b1, 8'd8}, // R8
        '{32'h00000180, 2'd1, 2'd2, 1'b0, 1'b1, 1'b1, 32'h80000000, 1'b1, 8'd8}, // R8
        '{32'h00000003, 2'd0, 2'd2, 1'b0, 1'b0, 1'b1, 32'h00000003, 1'b0, 8'd8}, // R8
        '{32'h11223344, 2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 32'h44112233, 1'b0, 8'd11}, // R11
        '{32'h00000105, 2'd0, 2'd3, 1'b0, 1'b1, 1'b0, 32'h00000105, 1'b1, 8'd11}  // R11
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 valid", {31'd0, out_valid}, 32'd0);
        check("R10 branch", {31'd0, branch_req}, 32'd0);
        check("R10 data", out_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            rd_word = VECS[i].word;  addr_lo = VECS[i].off;  acc_size = VECS[i].sz;
            sign_ext = VECS[i].sgn;  dest_pc = VECS[i].pc;   pc_bit0_clear = VECS[i].clr;
            in_valid = 1'b1;
            @(negedge clk);
            check($sformatf("R%0d data", VECS[i].req), out_data, VECS[i].exp_data);
            check($sformatf("R%0d branch", VECS[i].req), {31'd0, branch_req}, {31'd0, VECS[i].exp_br});
            check("R9 valid", {31'd0, out_valid}, 32'd1);
        end

        // R9: hold when strobe low, inputs changed
        in_valid = 1'b0;
        rd_word = 32'hDEADBEEF; acc_size = 2'd2; dest_pc = 1'b1; addr_lo = 2'd0;
        @(negedge clk);
        @(negedge clk);
        check("R9 hold data", out_data, 32'h00000105);
        check("R9 valid low", {31'd0, out_valid}, 32'd0);
        check("R9 branch low", {31'd0, branch_req}, 32'd0);

        // R9: single-cycle pulse
        in_valid = 1'b1; dest_pc = 1'b0; acc_size = 2'd0; sign_ext = 1'b0; addr_lo = 2'd2;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 pulse valid", {31'd0, out_valid}, 32'd1);
        check("R2 pulse data", out_data, 32'h000000AD);
        @(negedge clk);
        check("R9 pulse end", {31'd0, out_valid}, 32'd0);

        // R10: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid data", out_data, 32'd0);
        check("R10 mid valid", {31'd0, out_valid}, 32'd0);

        done = 1'b1;
        summary();
    end

endmodule